// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the operand address for an 8-bit processor core that addresses 16 bits of memory. Each operation is launched by a one-cycle `start` pulse that comes with a mode code and a byte/word size flag. The same pulse carries the current value of the selected 16-bit general register, the long (16-bit) and short (8-bit) fields taken from the instruction stream, and the address of the following instruction. The unit answers with registered results. These are an effective address with its valid strobe, an operand path for register-direct and immediate modes, a register writeback value and strobe for the auto-increment and auto-decrement modes, and an alignment-error flag.

Memory-indirect mode needs one extra memory read, which fetches the pointer word. The unit drives a small read port for it, using a request/acknowledge handshake. While that read is outstanding, the unit is busy and ignores new `start` pulses. All other modes finish in the cycle after `start`.

The controller has two states. `ST_IDLE` waits for `start`. `ST_FETCH` holds the pointer read request. The state changes in two ways:
- `IDLE->FETCH` happens on `start` with the memory-indirect code.
- `FETCH->IDLE` happens on `rd_ack`.

Every other `start` is a self-loop on `ST_IDLE`.

Mode codes on `mode`:

| Code | Mode |
|------|------|
| 0 | register direct |
| 1 | register indirect |
| 2 | register plus 16-bit displacement |
| 3 | post-increment |
| 4 | pre-decrement |
| 5 | 8-bit absolute |
| 6 | 16-bit absolute |
| 7 | 8-bit immediate |
| 8 | 16-bit immediate |
| 9 | PC-relative |
| 10 | memory indirect |

Codes 11 to 15 are reserved.

Top module: `eag_top`

## Requirements
- R1: After reset, `done`, `ea_valid`, `opnd_valid`, `wb_en`, `align_err`, `rd_req` and `busy` are all low.
- R2: For every code other than 10, a `start` seen in idle gives `done` high for exactly one cycle, in the cycle after `start`. In that cycle `rd_req` stays low.
- R3: Code 1 gives `ea` = register. Code 2 gives `ea` = register + `ext_long`, modulo 2^16. Both assert `ea_valid`.
- R4: Code 3 gives `ea` = register. It also asserts `wb_en` with `wb_val` = register + 1 for bytes (`word`=0) or + 2 for words (`word`=1), modulo 2^16.
- R5: Code 4 gives `ea` = `wb_val` = register − 1 for bytes or − 2 for words, modulo 2^16, with `wb_en` high. No other code asserts `wb_en`.
- R6: Code 5 gives `ea` = 0xFF00 | `ext_short`. Code 6 gives `ea` = `ext_long`.
- R7: Code 9 gives `ea` = `next_pc` + the sign-extended `ext_short`, modulo 2^16.
- R8: Codes 0, 7, 8 and 11–15 keep `ea_valid` low and assert `opnd_valid`, with the following `opnd` values:
  - Code 0 and codes 11–15: the register in word size, or its low byte zero-extended in byte size.
  - Code 7: `ext_short` zero-extended.
  - Code 8: `ext_long`.
- R9: Code 10 raises `rd_req` in the next cycle, with `rd_addr` = 0x00 | `ext_short`. Both are held, and `busy` stays high, until a cycle with `rd_ack`. In the cycle after that one, `done` and `ea_valid` rise with `ea` = the `rd_data` that was presented with `rd_ack`, and `rd_req` has dropped.
- R10: `align_err` rises together with `ea_valid` exactly when `word` = 1 and the resulting `ea` is odd. It never rises for byte accesses or for modes that have no address.
- R11: A `start` that arrives while a pointer fetch is pending has no effect. This includes a `start` in the same cycle as `rd_ack`. It produces no `done`, and it changes neither the fetch nor its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch an address computation |
| mode | input | 4 | Addressing mode code |
| word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| reg_val | input | ADDR_W (16) | Selected general register |
| ext_long | input | ADDR_W (16) | 16-bit displacement, absolute address or immediate |
| ext_short | input | SHORT_W (8) | 8-bit absolute address, immediate or displacement |
| next_pc | input | ADDR_W (16) | Address of the following instruction |
| rd_ack | input | 1 | Pointer read data valid |
| rd_data | input | ADDR_W (16) | Pointer word |
| busy | output | 1 | Pointer fetch outstanding |
| done | output | 1 | One-cycle completion pulse |
| ea_valid | output | 1 | `ea` holds a memory address |
| ea | output | ADDR_W (16) | Effective address |
| opnd_valid | output | 1 | `opnd` holds the operand |
| opnd | output | ADDR_W (16) | Register or immediate operand |
| wb_en | output | 1 | Write `wb_val` back to the register |
| wb_val | output | ADDR_W (16) | Updated register value |
| align_err | output | 1 | Word access at an odd address |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | ADDR_W (16) | Pointer read address |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both.

The first pair is the completion of a pointer fetch and a fresh `start`. The bench raises `start` with a register-direct code in exactly the cycle that carries `rd_ack`, and again during wait cycles of the fetch. It judges the outcome from three observations: only the fetched pointer appears, `opnd_valid` stays low, and no second `done` follows.

The second pair is the alignment error and the address strobe. The sweep feeds odd and even registers, displacements and pointer words under both sizes. In the completion cycle it then compares `align_err`, `ea_valid` and `wb_en` against values the bench computes itself.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W_DEF  = 16;
    localparam int SHORT_W_DEF = 8;

    typedef enum logic [3:0] {
        M_REG     = 4'd0,
        M_IND     = 4'd1,
        M_DISP    = 4'd2,
        M_POSTINC = 4'd3,
        M_PREDEC  = 4'd4,
        M_ABS8    = 4'd5,
        M_ABS16   = 4'd6,
        M_IMM8    = 4'd7,
        M_IMM16   = 4'd8,
        M_PCREL   = 4'd9,
        M_MEMIND  = 4'd10,
        M_RSV11   = 4'd11,
        M_RSV12   = 4'd12,
        M_RSV13   = 4'd13,
        M_RSV14   = 4'd14,
        M_RSV15   = 4'd15
    } mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } eag_state_e;

endpackage

// File: rtl/eag_calc.sv
module eag_calc
    import eag_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int SHORT_W = SHORT_W_DEF
) (
    input  mode_e               mode,
    input  logic                word,
    input  logic [ADDR_W-1:0]   reg_val,
    input  logic [ADDR_W-1:0]   ext_long,
    input  logic [SHORT_W-1:0]  ext_short,
    input  logic [ADDR_W-1:0]   next_pc,
    output logic [ADDR_W-1:0]   addr,
    output logic [ADDR_W-1:0]   opnd,
    output logic [ADDR_W-1:0]   wb,
    output logic                is_mem,
    output logic                has_opnd,
    output logic                has_wb,
    output logic                indirect
);

    localparam int HI_W = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] short_sext;
    logic [ADDR_W-1:0] short_zext;
    logic [ADDR_W-1:0] short_page;
    logic [ADDR_W-1:0] reg_narrow;

    always_comb begin
        step       = word ? ADDR_W'(2) : ADDR_W'(1);
        short_sext = {{HI_W{ext_short[SHORT_W-1]}}, ext_short};
        short_zext = {{HI_W{1'b0}}, ext_short};
        short_page = {{HI_W{1'b1}}, ext_short};
        reg_narrow = word ? reg_val : {{HI_W{1'b0}}, reg_val[SHORT_W-1:0]};
    end

    always_comb begin
        addr     = '0;
        opnd     = '0;
        wb       = reg_val;
        is_mem   = 1'b1;
        has_opnd = 1'b0;
        has_wb   = 1'b0;
        indirect = 1'b0;
        case (mode)
            M_REG: begin
                is_mem   = 1'b0;
                has_opnd = 1'b1;
                opnd     = reg_narrow;
            end
            M_IND:   addr = reg_val;
            M_DISP:  addr = reg_val + ext_long;
            M_POSTINC: begin
                addr   = reg_val;
                wb     = reg_val + step;
                has_wb = 1'b1;
            end
            M_PREDEC: begin
                addr   = reg_val - step;
                wb     = reg_val - step;
                has_wb = 1'b1;
            end
            M_ABS8:  addr = short_page;
            M_ABS16: addr = ext_long;
            M_IMM8: begin
                is_mem   = 1'b0;
                has_opnd = 1'b1;
                opnd     = short_zext;
            end
            M_IMM16: begin
                is_mem   = 1'b0;
                has_opnd = 1'b1;
                opnd     = ext_long;
            end
            M_PCREL: addr = next_pc + short_sext;
            M_MEMIND: begin
                addr     = short_zext;
                indirect = 1'b1;
            end
            default: begin
                is_mem   = 1'b0;
                has_opnd = 1'b1;
                opnd     = reg_narrow;
            end
        endcase
    end

    // R8: an operand path and a memory address are never offered together
    always_comb begin
        a_r8_calc_exclusive: assert (!(has_opnd && is_mem));
    end

endmodule

// File: rtl/eag_fsm.sv
module eag_fsm
    import eag_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               word,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  opnd,
    input  logic [ADDR_W-1:0]  wb,
    input  logic               is_mem,
    input  logic               has_opnd,
    input  logic               has_wb,
    input  logic               indirect,
    input  logic               rd_ack,
    input  logic [ADDR_W-1:0]  rd_data,
    output logic               busy,
    output logic               done_q,
    output logic               ea_v_q,
    output logic [ADDR_W-1:0]  ea_q,
    output logic               op_v_q,
    output logic [ADDR_W-1:0]  op_q,
    output logic               wb_en_q,
    output logic [ADDR_W-1:0]  wb_q,
    output logic               err_q,
    output logic               req_q,
    output logic [ADDR_W-1:0]  raddr_q
);

    eag_state_e state, state_n;
    logic       word_q;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start && indirect) state_n = ST_FETCH;
            ST_FETCH: if (rd_ack)            state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    assign busy = (state == ST_FETCH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            ea_v_q  <= 1'b0;
            ea_q    <= '0;
            op_v_q  <= 1'b0;
            op_q    <= '0;
            wb_en_q <= 1'b0;
            wb_q    <= '0;
            err_q   <= 1'b0;
            req_q   <= 1'b0;
            raddr_q <= '0;
            word_q  <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            ea_v_q  <= 1'b0;
            op_v_q  <= 1'b0;
            wb_en_q <= 1'b0;
            err_q   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start && indirect) begin
                        req_q   <= 1'b1;
                        raddr_q <= addr;
                        word_q  <= word;
                    end else if (start) begin
                        done_q  <= 1'b1;
                        ea_v_q  <= is_mem;
                        ea_q    <= addr;
                        op_v_q  <= has_opnd;
                        op_q    <= opnd;
                        wb_en_q <= has_wb;
                        wb_q    <= wb;
                        err_q   <= word && is_mem && addr[0];
                    end
                end
                ST_FETCH: begin
                    if (rd_ack) begin
                        req_q  <= 1'b0;
                        done_q <= 1'b1;
                        ea_v_q <= 1'b1;
                        ea_q   <= rd_data;
                        err_q  <= word_q && rd_data[0];
                    end
                end
            endcase
        end
    end

    // R2: single-cycle modes complete on the next edge
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !indirect) |=> done_q);

    // R9: request and address hold until acknowledged
    a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !rd_ack) |=> (req_q && $stable(raddr_q)));

    // R9: the returned pointer becomes the address
    a_r9_ea_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && rd_ack) |=> (ea_v_q && !req_q && ea_q == $past(rd_data)));

    // R10: alignment error only with an odd valid address
    a_r10_err_odd: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (ea_v_q && ea_q[0]));

    // R8: address and operand strobes are exclusive
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ea_v_q && op_v_q));

    // R11: no completion while a fetch is pending without acknowledge
    a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_ack) |=> !done_q);

    // R5: writeback only accompanies an address
    a_r5_wb_with_ea: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_q |-> ea_v_q);

endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int SHORT_W = SHORT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [3:0]         mode,
    input  logic               word,
    input  logic [ADDR_W-1:0]  reg_val,
    input  logic [ADDR_W-1:0]  ext_long,
    input  logic [SHORT_W-1:0] ext_short,
    input  logic [ADDR_W-1:0]  next_pc,
    input  logic               rd_ack,
    input  logic [ADDR_W-1:0]  rd_data,
    output logic               busy,
    output logic               done,
    output logic               ea_valid,
    output logic [ADDR_W-1:0]  ea,
    output logic               opnd_valid,
    output logic [ADDR_W-1:0]  opnd,
    output logic               wb_en,
    output logic [ADDR_W-1:0]  wb_val,
    output logic               align_err,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr
);

    mode_e             mode_t;
    logic [ADDR_W-1:0] c_addr;
    logic [ADDR_W-1:0] c_opnd;
    logic [ADDR_W-1:0] c_wb;
    logic              c_mem;
    logic              c_has_opnd;
    logic              c_has_wb;
    logic              c_indirect;

    assign mode_t = mode_e'(mode);

    eag_calc #(
        .ADDR_W  (ADDR_W),
        .SHORT_W (SHORT_W)
    ) u_calc (
        .mode      (mode_t),
        .word      (word),
        .reg_val   (reg_val),
        .ext_long  (ext_long),
        .ext_short (ext_short),
        .next_pc   (next_pc),
        .addr      (c_addr),
        .opnd      (c_opnd),
        .wb        (c_wb),
        .is_mem    (c_mem),
        .has_opnd  (c_has_opnd),
        .has_wb    (c_has_wb),
        .indirect  (c_indirect)
    );

    eag_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .word     (word),
        .addr     (c_addr),
        .opnd     (c_opnd),
        .wb       (c_wb),
        .is_mem   (c_mem),
        .has_opnd (c_has_opnd),
        .has_wb   (c_has_wb),
        .indirect (c_indirect),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .busy     (busy),
        .done_q   (done),
        .ea_v_q   (ea_valid),
        .ea_q     (ea),
        .op_v_q   (opnd_valid),
        .op_q     (opnd),
        .wb_en_q  (wb_en),
        .wb_q     (wb_val),
        .err_q    (align_err),
        .req_q    (rd_req),
        .raddr_q  (rd_addr)
    );

endmodule

// File: tb/sim_eag_top.sv
`timescale 1ns/100ps
module sim_eag_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic        word = 1'b0;
    logic [15:0] reg_val = '0;
    logic [15:0] ext_long = '0;
    logic [7:0]  ext_short = '0;
    logic [15:0] next_pc = '0;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = '0;
    logic        busy, done, ea_valid, opnd_valid, wb_en, align_err, rd_req;
    logic [15:0] ea, opnd, wb_val, rd_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    eag_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .word(word),
        .reg_val(reg_val), .ext_long(ext_long), .ext_short(ext_short),
        .next_pc(next_pc), .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy),
        .done(done), .ea_valid(ea_valid), .ea(ea), .opnd_valid(opnd_valid),
        .opnd(opnd), .wb_en(wb_en), .wb_val(wb_val), .align_err(align_err),
        .rd_req(rd_req), .rd_addr(rd_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pick16(input int k);
        logic [15:0] v;
        case (k % 8)
            0: v = 16'h0000; 1: v = 16'h0001; 2: v = 16'h7FFF; 3: v = 16'h8000;
            4: v = 16'hFFFE; 5: v = 16'hFFFF; 6: v = 16'h1235; default: v = 16'hA5A4;
        endcase
        return v;
    endfunction

    task automatic run_single(input int m, input bit w, input int i);
        logic [15:0] r, el, pc, step;
        logic [15:0] x_ea, x_op, x_wb;
        logic [7:0]  es;
        bit x_mem, x_opv, x_wbe, x_err;
        r = pick16(i); el = pick16(i + 3); es = pick16(i + 5) >> (i % 2 ? 8 : 0);
        pc = pick16(i + 1) ^ 16'h0F0F;
        step = w ? 16'd2 : 16'd1;
        x_ea = '0; x_op = '0; x_wb = '0; x_mem = 1; x_opv = 0; x_wbe = 0;
        case (m)
            1: x_ea = r;
            2: x_ea = r + el;
            3: begin x_ea = r; x_wb = r + step; x_wbe = 1; end
            4: begin x_ea = r - step; x_wb = r - step; x_wbe = 1; end
            5: x_ea = 16'hFF00 | {8'h00, es};
            6: x_ea = el;
            7: begin x_mem = 0; x_opv = 1; x_op = {8'h00, es}; end
            8: begin x_mem = 0; x_opv = 1; x_op = el; end
            9: x_ea = pc + {{8{es[7]}}, es};
            default: begin x_mem = 0; x_opv = 1; x_op = w ? r : {8'h00, r[7:0]}; end
        endcase
        x_err = w && x_mem && x_ea[0];
        @(negedge clk);
        mode = m[3:0]; word = w; reg_val = r; ext_long = el; ext_short = es;
        next_pc = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 done", done, 1);
        chk("R2 rd_req", rd_req, 0);
        chk("R8 ea_valid", ea_valid, x_mem);
        chk("R8 opnd_valid", opnd_valid, x_opv);
        chk("R5 wb_en", wb_en, x_wbe);
        chk("R10 align_err", align_err, x_err);
        if (x_mem) begin
            case (m)
                1, 2: chk("R3 ea", ea, x_ea);
                3: chk("R4 ea", ea, x_ea);
                4: chk("R5 ea", ea, x_ea);
                5, 6: chk("R6 ea", ea, x_ea);
                default: chk("R7 ea", ea, x_ea);
            endcase
        end
        if (x_opv) chk("R8 opnd", opnd, x_op);
        if (x_wbe) chk(m == 3 ? "R4 wb_val" : "R5 wb_val", wb_val, x_wb);
        @(negedge clk);
        chk("R2 done pulse", done, 0);
    endtask

    task automatic run_ind(input bit w, input logic [7:0] es, input logic [15:0] ptr,
                           input int wait_n, input bit inject);
        @(negedge clk);
        mode = 4'd10; word = w; ext_short = es; reg_val = 16'h4321; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 rd_req", rd_req, 1);
        chk("R9 rd_addr", rd_addr, {8'h00, es});
        chk("R9 busy", busy, 1);
        chk("R9 no done", done, 0);
        for (int k = 0; k < wait_n; k++) begin
            if (inject) begin mode = 4'd0; start = 1'b1; end
            ext_short = es ^ 8'h5A;
            @(negedge clk);
            start = 1'b0;
            chk("R11 no done while busy", done, 0);
            chk("R9 rd_req held", rd_req, 1);
            chk("R9 rd_addr held", rd_addr, {8'h00, es});
        end
        rd_ack = 1'b1; rd_data = ptr;
        if (inject) begin mode = 4'd0; start = 1'b1; end
        @(negedge clk);
        rd_ack = 1'b0; start = 1'b0; rd_data = 16'hDEAD;
        chk("R9 done", done, 1);
        chk("R9 ea_valid", ea_valid, 1);
        chk("R9 ea", ea, ptr);
        chk("R9 rd_req dropped", rd_req, 0);
        chk("R11 opnd_valid", opnd_valid, 0);
        chk("R10 align_err ind", align_err, w && ptr[0]);
        @(negedge clk);
        chk("R11 no extra done", done, 0);
        chk("R9 busy cleared", busy, 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 ea_valid", ea_valid, 0);
        chk("R1 opnd_valid", opnd_valid, 0);
        chk("R1 wb_en", wb_en, 0);
        chk("R1 align_err", align_err, 0);
        chk("R1 rd_req", rd_req, 0);
        chk("R1 busy", busy, 0);
        rst_n = 1'b1;
        for (int m = 0; m < 16; m++) begin
            if (m == 10) continue;
            for (int w = 0; w < 2; w++)
                for (int i = 0; i < 8; i++)
                    run_single(m, w[0], i);
        end
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 8; i++)
                run_ind(w[0], pick16(i + 2) >> 4, pick16(i + 6), i % 4, i[0]);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule